// File: doc/BRIEF.md
# Longest Prefix Match Engine

This block resolves a 32-bit IPv4 destination address to a next-hop identifier. It keeps a small table of route entries. Each entry is a prefix value, a prefix length and an 8-bit next hop. On every lookup the address is compared with all valid entries at once. Only the leading address bits covered by an entry's length take part in that entry's comparison. Among the entries that match, the one with the greatest length supplies the result, so a more specific route overrides a broader one wherever it sits in the table.

Software or a control engine loads the table through a one-entry-per-cycle write port. The datapath issues a lookup by raising a request strobe with the address. The result comes back a fixed two cycles later with a hit flag and the next hop. When no entry matches, the result carries a default-route flag instead, so the caller can send the packet to its default gateway. A new lookup may start every cycle, which keeps up with minimum-size packets at line rate.

Top module: `lpm_engine`

## Requirements
- R1: A write with `wr_en` high at a rising edge stores (`wr_valid`, `wr_prefix`, `wr_len`, `wr_next_hop`) into slot `wr_idx` (0 to 31), replacing the old contents. Lookups started after that edge see the new entry. Writing `wr_valid`=0 removes the slot from matching.
- R2: An entry matches an address when it is valid and the top `len` bits of the address equal the top `len` bits of its prefix. Prefix bits below the length are ignored.
- R3: When several entries match, the result comes from the matching entry with the greatest length, whatever its slot number.
- R4: When two or more matching entries share the greatest length, the one in the lowest-numbered slot wins.
- R5: A request (`req_valid` high at rising edge k) produces exactly one result. `res_valid` is high for one cycle after rising edge k+1, with the result fields valid in that cycle. Requests may be issued on consecutive cycles, and each yields its own result in order.
- R6: A lookup with no matching entry returns `res_hit`=0, `res_default`=1 and `res_next_hop`=0. A hit returns `res_hit`=1, `res_default`=0 and the winner's next hop.
- R7: An entry whose length is 0 or greater than 32 never matches. An entry of length 32 matches only the exact address.
- R8: A synchronous active-low reset empties the table (every slot invalid) and drives `res_valid`, `res_hit`, `res_default` and `res_next_hop` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Destination address to resolve |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 5 | Slot to write |
| wr_valid | input | 1 | Valid bit written into the slot |
| wr_prefix | input | 32 | Prefix value written into the slot |
| wr_len | input | 6 | Prefix length written into the slot |
| wr_next_hop | input | 8 | Next hop written into the slot |
| res_valid | output | 1 | Result strobe, two cycles after the request |
| res_hit | output | 1 | At least one entry matched |
| res_default | output | 1 | No entry matched; use the default route |
| res_next_hop | output | 8 | Next hop of the longest match, 0 on a miss |

## Verification
A corrupted table slot or a wrong length mask shows up at the ports on the first lookup whose address falls under that slot. It appears as a wrong next hop or a flipped hit/default pair, two cycles after the request. A fault in the longest-length or lowest-slot ordering appears only when overlapping prefixes match the same address. For that reason the random table is built from a few shared base addresses, and directed cases cover equal-length ties. A slipped pipeline stage shows as `res_valid` one cycle early or late, or as results out of order in a back-to-back run.

// File: rtl/lpm_pkg.sv
// Shared widths and the route entry type for the prefix match engine.
// Assumes a small table that is searched in parallel on every lookup.
package lpm_pkg;
    localparam int ADDR_W = 32;
    localparam int LEN_W  = 6;
    localparam int NH_W   = 8;
    localparam int DEPTH  = 32;
    localparam int IDX_W  = $clog2(DEPTH);

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] pfx;
        logic [LEN_W-1:0]  len;
        logic [NH_W-1:0]   nh;
    } route_t;
endpackage

// File: rtl/lpm_table.sv
// Route table storage: one write port, all slots visible in parallel.
// Assumes writes and lookups are ordered by the caller. Reset clears only the valid bits.
module lpm_table
    import lpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  route_t           wr_entry,
    output route_t           slots [DEPTH]
);
    // Store one entry per write; invalidate all slots on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots[i].vld <= 1'b0;
        end else if (wr_en) begin
            slots[wr_idx] <= wr_entry;
        end
    end

    // R1: the addressed slot takes the written valid bit
    p_write_vld_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> slots[$past(wr_idx)].vld == $past(wr_entry.vld));
endmodule

// File: rtl/lpm_match.sv
// Per-slot comparator: flags every slot whose prefix covers the address.
// Assumes lengths outside 1..ADDR_W denote unusable entries.
module lpm_match
    import lpm_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  route_t            slots [DEPTH],
    output logic [DEPTH-1:0]  hit_vec
);
    function automatic logic [ADDR_W-1:0] len_mask(input logic [LEN_W-1:0] len);
        return ~({ADDR_W{1'b1}} >> len);
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic len_ok;
        logic [ADDR_W-1:0] msk;
        // Compare the covered address bits of slot g.
        always_comb begin
            len_ok     = (slots[g].len != '0) && (int'(slots[g].len) <= ADDR_W);
            msk        = len_mask(slots[g].len);
            hit_vec[g] = slots[g].vld && len_ok && (((addr ^ slots[g].pfx) & msk) == '0);
        end
    end
endmodule

// File: rtl/lpm_select.sv
// Winner selection: longest matching length, lowest slot on a tie.
// Assumes hit_vec comes from lpm_match for the same table snapshot.
module lpm_select
    import lpm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] hit_vec,
    input  route_t           slots [DEPTH],
    output logic             found,
    output logic [IDX_W-1:0] win_idx,
    output logic [LEN_W-1:0] win_len
);
    // Scan slots upward; a strictly longer match replaces the current pick.
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_len = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (hit_vec[i] && (!found || slots[i].len > win_len)) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_len = slots[i].len;
            end
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_chk
        // R3: no matching slot is longer than the winner
        p_longest_r3: assert property (@(posedge clk) disable iff (!rst_n)
            hit_vec[g] |-> (found && slots[g].len <= win_len));
        // R4: a tied matching slot never sits below the winner
        p_tie_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_vec[g] && slots[g].len == win_len) |-> (int'(win_idx) <= g));
    end
endmodule

// File: rtl/lpm_engine.sv
// Longest prefix match engine top. Stage 1 registers the request; stage 2
// matches against the table and registers the result (two-cycle latency).
// Assumes the table is not rewritten while a lookup is in flight.
module lpm_engine
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_prefix,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic [NH_W-1:0]   wr_next_hop,
    output logic              res_valid,
    output logic              res_hit,
    output logic              res_default,
    output logic [NH_W-1:0]   res_next_hop
);
    route_t            slots [DEPTH];
    route_t            wr_entry;
    logic              s1_vld;
    logic [ADDR_W-1:0] s1_addr;
    logic [DEPTH-1:0]  hit_vec;
    logic              found;
    logic [IDX_W-1:0]  win_idx;
    logic [LEN_W-1:0]  win_len;

    // Pack the write port fields into one entry.
    always_comb wr_entry = '{vld: wr_valid, pfx: wr_prefix, len: wr_len, nh: wr_next_hop};

    lpm_table u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_entry(wr_entry), .slots(slots)
    );

    lpm_match u_match (.addr(s1_addr), .slots(slots), .hit_vec(hit_vec));

    lpm_select u_select (
        .clk(clk), .rst_n(rst_n), .hit_vec(hit_vec), .slots(slots),
        .found(found), .win_idx(win_idx), .win_len(win_len)
    );

    // Stage 1: capture the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld  <= 1'b0;
            s1_addr <= '0;
        end else begin
            s1_vld  <= req_valid;
            s1_addr <= req_addr;
        end
    end

    // Stage 2: register the lookup outcome.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid    <= 1'b0;
            res_hit      <= 1'b0;
            res_default  <= 1'b0;
            res_next_hop <= '0;
        end else begin
            res_valid    <= s1_vld;
            res_hit      <= s1_vld && found;
            res_default  <= s1_vld && !found;
            res_next_hop <= (s1_vld && found) ? slots[win_idx].nh : '0;
        end
    end

    // R5: every result strobe follows a request two edges earlier
    p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(req_valid, 2));
    // R6: a miss carries the default flag and a zero next hop
    p_miss_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_default && res_next_hop == '0));
    // R8: idle cycles show no hit and no default
    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_default));
endmodule

// File: tb/test_lpm_engine.sv
module test_lpm_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_prefix = '0;
    logic [5:0]  wr_len = '0;
    logic [7:0]  wr_next_hop = '0;
    logic        res_valid, res_hit, res_default;
    logic [7:0]  res_next_hop;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Bench copy of the table, kept from the requirements.
    bit          m_v [32];
    logic [31:0] m_p [32];
    logic [5:0]  m_l [32];
    logic [7:0]  m_n [32];

    always #4 clk = ~clk;

    lpm_engine i_lpm_engine (.*);

    function automatic bit covers(input logic [31:0] a, input int k);
        if (!m_v[k] || m_l[k] == 0 || m_l[k] > 32) return 0;
        for (int b = 0; b < 32; b++)
            if (b < m_l[k] && a[31-b] != m_p[k][31-b]) return 0;
        return 1;
    endfunction

    // Returns -1 on miss, else the winning slot.
    function automatic int model(input logic [31:0] a);
        int best = -1;
        for (int k = 0; k < 32; k++)
            if (covers(a, k) && (best < 0 || m_l[k] > m_l[best])) best = k;
        return best;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input int k, input bit v, input logic [31:0] p, input int l, input int n);
        @(negedge clk);
        wr_en = 1; wr_idx = 5'(k); wr_valid = v; wr_prefix = p; wr_len = 6'(l); wr_next_hop = 8'(n);
        m_v[k] = v; m_p[k] = p; m_l[k] = 6'(l); m_n[k] = 8'(n);
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic clear_all();
        for (int k = 0; k < 32; k++) put(k, 0, 0, 0, 0);
    endtask

    task automatic expect_result(input string req, input int w);
        check({req, " valid"}, {31'b0, res_valid}, 1);
        check({req, " hit"}, {31'b0, res_hit}, {31'b0, w >= 0});
        check({req, " default"}, {31'b0, res_default}, {31'b0, w < 0});
        check({req, " next_hop"}, {24'b0, res_next_hop}, w >= 0 ? {24'b0, m_n[w]} : 0);
    endtask

    // Single lookup: drive, wait two edges, sample at the following falling edge.
    task automatic look(input string req, input logic [31:0] a);
        @(negedge clk);
        req_valid = 1; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        check({req, " early strobe"}, {31'b0, res_valid}, 0);
        @(negedge clk);
        expect_result(req, model(a));
        @(negedge clk);
        check({req, " single strobe"}, {31'b0, res_valid}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] bases [4];
        logic [31:0] hist [3];
        bit hv [3];
        void'($urandom(32'd1234));
        for (int k = 0; k < 32; k++) begin m_v[k] = 0; m_p[k] = 0; m_l[k] = 0; m_n[k] = 0; end

        // R8: reset state
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R8 res_valid", {31'b0, res_valid}, 0);
        check("R8 res_hit", {31'b0, res_hit}, 0);
        check("R8 res_next_hop", {24'b0, res_next_hop}, 0);
        put(3, 1, 32'h0A000000, 8, 77);
        look("R1 load then hit", 32'h0A123456);
        @(negedge clk); rst_n = 0; @(negedge clk); rst_n = 1;
        m_v[3] = 0;
        look("R8 reset empties table", 32'h0A123456);

        // Routing example: R2, R3
        put(0, 1, 32'h80090000, 16, 1);
        put(1, 1, 32'h800910FF, 21, 2);   // low bits set, ignored per R2
        put(2, 1, 32'h8009B000, 24, 3);
        put(3, 1, 32'h8009AC00, 21, 4);
        put(4, 1, 32'h8E0C0000, 19, 5);
        put(5, 1, 32'h41000000, 8, 6);
        put(30, 1, 32'h80000000, 1, 9);
        look("R3 128.9.16.14 picks /21", 32'h8009100E);
        check("R3 model picks slot 1", model(32'h8009100E), 1);
        look("R3 /24 deeper", 32'h8009B001);
        look("R2 /16 only", 32'h8009FF00);
        look("R2 /1 only", 32'h90000000);
        look("R6 miss", 32'h01020304);

        // R4: equal-length tie, lowest slot wins
        put(10, 1, 32'hC0A80000, 16, 40);
        put(8, 1, 32'hC0A8FFFF, 16, 41);
        look("R4 tie lowest slot", 32'hC0A80101);
        check("R4 model slot 8", model(32'hC0A80101), 8);

        // R7: bad lengths and exact /32
        put(12, 1, 32'h11223344, 0, 50);
        put(13, 1, 32'h11223344, 40, 51);
        look("R7 len 0 and >32 ignored", 32'h11223344);
        put(14, 1, 32'h11223344, 32, 52);
        look("R7 exact /32 hit", 32'h11223344);
        look("R7 /32 off by one", 32'h11223345);

        // R1: overwrite and invalidate
        put(1, 1, 32'h80091000, 21, 99);
        look("R1 overwrite next hop", 32'h8009100E);
        put(1, 0, 32'h80091000, 21, 99);
        look("R1 invalidated slot", 32'h8009100E);

        // Random overlapping tables: R2, R3, R4, R6
        for (int t = 0; t < 6; t++) begin
            clear_all();
            for (int b = 0; b < 4; b++) bases[b] = $urandom;
            for (int k = 0; k < 32; k++)
                if ($urandom_range(0, 9) < 8)
                    put(k, 1, bases[$urandom_range(0, 3)] ^ ($urandom >> $urandom_range(4, 31)),
                        $urandom_range(1, 32), $urandom_range(1, 255));
            for (int q = 0; q < 40; q++)
                look("R3 random", bases[$urandom_range(0, 3)] ^ ($urandom >> $urandom_range(0, 31)));

            // R5: back-to-back requests, each result two edges later, in order
            for (int c = 0; c < 3; c++) hv[c] = 0;
            for (int c = 0; c < 24; c++) begin
                @(negedge clk);
                if (hv[0]) expect_result("R5 back-to-back", model(hist[0]));
                else check("R5 no strobe before first", {31'b0, res_valid}, 0);
                hist[0] = hist[1]; hv[0] = hv[1];
                hist[1] = bases[$urandom_range(0, 3)] ^ ($urandom >> $urandom_range(0, 31));
                hv[1] = 1;
                req_valid = 1; req_addr = hist[1];
            end
            @(negedge clk);
            req_valid = 0;
            expect_result("R5 back-to-back", model(hist[0]));
            @(negedge clk);
            expect_result("R5 last", model(hist[1]));
            @(negedge clk);
            check("R5 strobe drops", {31'b0, res_valid}, 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule